// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block sits next to a small processor core and decides which interrupt source gets serviced next. Its inputs are an active-low general interrupt pin, an active-low pin for the high-priority non-maskable-style request, a periodic timer request, a vector of peripheral flags, and two strobes: one for a software interrupt and one for an illegal-opcode trap. The core supplies its I mask bit and an instruction-boundary strobe. The block owns the X mask. X comes out of reset set. It is cleared by a strobe from the core, which software or the return path raises, and it is set again only when the core accepts an XIRQ entry.

At each instruction boundary, and only while no entry is outstanding, the block picks the eligible source of highest priority. It then registers that source's 16-bit vector address and the mask updates the core must apply. The result is offered on a valid/ready pair. `ent_valid` is high while an entry is offered and `ent_ready` is the core's acceptance. While valid is high and ready is low, the vector and the mask updates do not change and no new sampling takes place. A cycle with both high completes the transfer. In that cycle the latched request of the accepted source is consumed, and valid drops in the next cycle.

A small write port configures the general interrupt pin. It selects low-level or falling-edge detection and enables the pin. The same port selects one maskable source to promote above all other maskable sources.

Top module: `irq_arbiter`

## Requirements
- R1: After reset `ent_valid` is 0, `ent_vec` is 0x0000, `x_mask` is 1, the general pin is in level mode and disabled, and the promotion code is 0.
- R2: `ent_valid` rises only in the cycle after a cycle in which `insn_bnd` was 1, `ent_valid` was 0 and at least one source was eligible. With nothing eligible it stays 0.
- R3: While `ent_valid`=1 and `ent_ready`=0, `ent_valid`, `ent_vec`, `ent_set_i` and `ent_set_x` hold. A cycle with both 1 makes `ent_valid` 0 in the next cycle.
- R4: The vector is 0xFFF8 minus twice the source index. The indices are trap 0 (0xFFF8), software 1 (0xFFF6), XIRQ 2 (0xFFF4), general pin 3 (0xFFF2), timer 4 (0xFFF0) and peripheral k at 5+k (0xFFEE-2k). Every vector is even and lies inside 0xFF80..0xFFF8.
- R5: With no promotion in effect, the order from highest priority down is trap, software, XIRQ, general pin, timer, then peripheral 0 through peripheral NPER-1.
- R6: Control write (`cfg_sel`=0) bit 0 = 0 selects level mode. In level mode `irq_n` is a request only when it is low in the boundary cycle, and each boundary that sees it low requests again.
- R7: Control bit 0 = 1 selects edge mode. A falling edge of `irq_n` sets a latch that is eligible from the next cycle and persists after the pin returns high. Acceptance of the general-pin entry clears the latch. Selecting level mode discards it.
- R8: Control bit 1 enables the general pin. When it is 0, the pin and its latch never win.
- R9: `cpu_i`=1 makes the general pin, the timer and the peripherals ineligible. It does not affect XIRQ, software or trap.
- R10: `x_clr` clears `x_mask`. `x_mask` becomes 1 only in the cycle after an XIRQ entry is accepted. A low `xirq_n` is eligible only while `x_mask` is 0.
- R11: A pulse on `swi_stb` or `trap_stb` is held as a request from the next cycle until an entry of that source is accepted.
- R12: `ent_set_i` is 1 for every entry. `ent_set_x` is 1 only for the XIRQ entry.
- R13: Promotion write (`cfg_sel`=1) code p selects a maskable source: 0 is the general pin, 1 is the timer, 2+k is peripheral k. That source ranks above the other maskable sources and below XIRQ. A code of NPER+2 or more is ignored and the previous code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_bnd | input | 1 | Instruction boundary strobe (sampling point) |
| irq_n | input | 1 | General interrupt pin, active low |
| xirq_n | input | 1 | X-masked interrupt pin, active low |
| tmr_req | input | 1 | Periodic timer request |
| per_req | input | NPER | Peripheral request flags, bit k is peripheral k |
| swi_stb | input | 1 | Software interrupt strobe |
| trap_stb | input | 1 | Illegal-opcode trap strobe |
| cpu_i | input | 1 | Core I mask bit |
| x_clr | input | 1 | Clear strobe for the X mask |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control (bit0 edge, bit1 enable), 1 = promotion code |
| cfg_wdata | input | 8 | Configuration write data |
| ent_ready | input | 1 | Core accepts the offered entry |
| ent_valid | output | 1 | Entry offered (interrupt pending) |
| ent_vec | output | 16 | Vector address of the offered entry |
| ent_set_i | output | 1 | Entry sets the I mask |
| ent_set_x | output | 1 | Entry sets the X mask |
| x_mask | output | 1 | Current X mask |

## Verification
The hardest situations to reach are the ones where a held request and a consumed one interact. One is an edge latch that must survive a long stall of the entry handshake. Another is a strobe that arrives in the same cycle as the acceptance of another entry. A third is an XIRQ that is low while X is set and must wait for the clear. Directed phases build each of these in turn: an edge with the pin released before the boundary, XIRQ held under a set X and then cleared, and both strobes pulsed before a single boundary. A long phase follows with random pins, strobes, ready stalls and configuration writes. A behavioural reference model checks every cycle of it, so acceptances land on every kind of latched state.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned SRC_TRAP = 0;
  localparam int unsigned SRC_SWI  = 1;
  localparam int unsigned SRC_XIRQ = 2;
  localparam int unsigned SRC_IRQ  = 3;
  localparam int unsigned SRC_TMR  = 4;
  localparam int unsigned SRC_PER0 = 5;
  localparam int unsigned NFIXED   = 5;

  localparam logic [15:0] VEC_TOP   = 16'hFFF8;
  localparam logic [15:0] VEC_FLOOR = 16'hFF80;

  typedef enum logic {
    CFG_CTRL  = 1'b0,
    CFG_PROMO = 1'b1
  } cfg_sel_e;

  function automatic logic [15:0] vec_of(input int unsigned id);
    return VEC_TOP - 16'(2 * id);
  endfunction
endpackage

// File: rtl/irqc_cfg.sv
module irqc_cfg
  import irqc_pkg::*;
#(
  parameter int NPER = 8,
  parameter int PW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic          edge_mode,
  output logic          irq_en,
  output logic [PW-1:0] promo
);
  localparam int NMASK = 2 + NPER;

  logic wr_ctrl, wr_promo, promo_ok;
  assign wr_ctrl  = cfg_wr && (cfg_sel == CFG_CTRL);
  assign wr_promo = cfg_wr && (cfg_sel == CFG_PROMO);
  assign promo_ok = int'(cfg_wdata) < NMASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_mode <= 1'b0;
      irq_en    <= 1'b0;
      promo     <= '0;
    end else begin
      if (wr_ctrl) begin
        edge_mode <= cfg_wdata[0];
        irq_en    <= cfg_wdata[1];
      end
      if (wr_promo && promo_ok) promo <= cfg_wdata[PW-1:0];
    end
  end

  // R13
  promo_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel && (int'(cfg_wdata) >= NMASK)) |=> $stable(promo));
endmodule

// File: rtl/irqc_srcs.sv
module irqc_srcs
  import irqc_pkg::*;
#(
  parameter int NPER = 8,
  parameter int NSRC = 13,
  parameter int IW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_n,
  input  logic            xirq_n,
  input  logic            tmr_req,
  input  logic [NPER-1:0] per_req,
  input  logic            swi_stb,
  input  logic            trap_stb,
  input  logic            cpu_i,
  input  logic            x_clr,
  input  logic            edge_mode,
  input  logic            irq_en,
  input  logic            take,
  input  logic [IW-1:0]   take_id,
  output logic [NSRC-1:0] elig,
  output logic            x_mask
);
  logic irq_prev, edge_q, swi_q, trap_q, x_q;
  logic take_irq, take_swi, take_trap, take_xirq, irq_fall;

  assign take_irq  = take && (take_id == IW'(SRC_IRQ));
  assign take_swi  = take && (take_id == IW'(SRC_SWI));
  assign take_trap = take && (take_id == IW'(SRC_TRAP));
  assign take_xirq = take && (take_id == IW'(SRC_XIRQ));
  assign irq_fall  = irq_prev && !irq_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_prev <= 1'b1;
      edge_q   <= 1'b0;
      swi_q    <= 1'b0;
      trap_q   <= 1'b0;
      x_q      <= 1'b1;
    end else begin
      irq_prev <= irq_n;
      if (edge_mode && irq_fall)        edge_q <= 1'b1;
      else if (!edge_mode || take_irq)  edge_q <= 1'b0;
      if (swi_stb)        swi_q  <= 1'b1;
      else if (take_swi)  swi_q  <= 1'b0;
      if (trap_stb)       trap_q <= 1'b1;
      else if (take_trap) trap_q <= 1'b0;
      if (take_xirq)      x_q    <= 1'b1;
      else if (x_clr)     x_q    <= 1'b0;
    end
  end

  logic irq_line;
  assign irq_line = edge_mode ? edge_q : !irq_n;

  assign elig[SRC_TRAP] = trap_q;
  assign elig[SRC_SWI]  = swi_q;
  assign elig[SRC_XIRQ] = !xirq_n && !x_q;
  assign elig[SRC_IRQ]  = irq_en && irq_line && !cpu_i;
  assign elig[SRC_TMR]  = tmr_req && !cpu_i;

  for (genvar k = 0; k < NPER; k++) begin : g_per
    assign elig[SRC_PER0 + k] = per_req[k] && !cpu_i;
  end

  assign x_mask = x_q;

  // R10
  x_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_q) |-> $past(take_xirq));
  // R7
  edge_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_q && edge_mode && !take_irq) |=> edge_q);
  // R11
  swi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (swi_q && !take_swi) |=> swi_q);
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick
  import irqc_pkg::*;
#(
  parameter int NPER = 8,
  parameter int NSRC = 13,
  parameter int IW   = 4,
  parameter int PW   = 4
) (
  input  logic [NSRC-1:0] elig,
  input  logic [PW-1:0]   promo,
  output logic            hit,
  output logic [IW-1:0]   win_id
);
  localparam int NMASK = 2 + NPER;

  always_comb begin
    hit    = 1'b0;
    win_id = '0;
    for (int s = NSRC - 1; s >= int'(SRC_IRQ); s--) begin
      if (elig[s]) begin
        hit    = 1'b1;
        win_id = IW'(s);
      end
    end
    for (int m = 0; m < NMASK; m++) begin
      if ((int'(promo) == m) && elig[int'(SRC_IRQ) + m]) begin
        hit    = 1'b1;
        win_id = IW'(int'(SRC_IRQ) + m);
      end
    end
    for (int s = int'(SRC_XIRQ); s >= 0; s--) begin
      if (elig[s]) begin
        hit    = 1'b1;
        win_id = IW'(s);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irqc_pkg::*;
#(
  parameter int NPER = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            insn_bnd,
  input  logic            irq_n,
  input  logic            xirq_n,
  input  logic            tmr_req,
  input  logic [NPER-1:0] per_req,
  input  logic            swi_stb,
  input  logic            trap_stb,
  input  logic            cpu_i,
  input  logic            x_clr,
  input  logic            cfg_wr,
  input  logic            cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic            ent_ready,
  output logic            ent_valid,
  output logic [15:0]     ent_vec,
  output logic            ent_set_i,
  output logic            ent_set_x,
  output logic            x_mask
);
  localparam int NSRC  = int'(NFIXED) + NPER;
  localparam int NMASK = 2 + NPER;
  localparam int IW    = $clog2(NSRC);
  localparam int PW    = $clog2(NMASK);

  logic            edge_mode, irq_en;
  logic [PW-1:0]   promo;
  logic [NSRC-1:0] elig;
  logic            hit;
  logic [IW-1:0]   win_id, id_q;
  logic            take;

  assign take = ent_valid && ent_ready;

  irqc_cfg #(.NPER(NPER), .PW(PW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .edge_mode(edge_mode), .irq_en(irq_en),
    .promo(promo)
  );

  irqc_srcs #(.NPER(NPER), .NSRC(NSRC), .IW(IW)) u_srcs (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .xirq_n(xirq_n),
    .tmr_req(tmr_req), .per_req(per_req), .swi_stb(swi_stb),
    .trap_stb(trap_stb), .cpu_i(cpu_i), .x_clr(x_clr),
    .edge_mode(edge_mode), .irq_en(irq_en), .take(take),
    .take_id(id_q), .elig(elig), .x_mask(x_mask)
  );

  irqc_pick #(.NPER(NPER), .NSRC(NSRC), .IW(IW), .PW(PW)) u_pick (
    .elig(elig), .promo(promo), .hit(hit), .win_id(win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_valid <= 1'b0;
      ent_vec   <= 16'h0000;
      ent_set_i <= 1'b0;
      ent_set_x <= 1'b0;
      id_q      <= '0;
    end else if (take) begin
      ent_valid <= 1'b0;
    end else if (!ent_valid && insn_bnd && hit) begin
      ent_valid <= 1'b1;
      ent_vec   <= vec_of(int'(win_id));
      ent_set_i <= 1'b1;
      ent_set_x <= (win_id == IW'(SRC_XIRQ));
      id_q      <= win_id;
    end
  end

  // R2
  sample_pt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ent_valid) |-> $past(insn_bnd));
  // R3
  entry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && !ent_ready) |=> (ent_valid && $stable(ent_vec) && $stable(ent_set_x)));
  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_vec >= VEC_FLOOR && ent_vec <= VEC_TOP && !ent_vec[0]));
  // R12
  mask_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |-> (ent_set_i && (ent_set_x == (ent_vec == vec_of(SRC_XIRQ)))));
  // R9
  imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ent_valid) && ent_vec < vec_of(SRC_XIRQ)) |-> !$past(cpu_i));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int NPER  = 8;
  localparam int NSRC  = 5 + NPER;
  localparam int NMASK = 2 + NPER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic insn_bnd = 0, irq_n = 1, xirq_n = 1, tmr_req = 0;
  logic [NPER-1:0] per_req = '0;
  logic swi_stb = 0, trap_stb = 0, cpu_i = 0, x_clr = 0;
  logic cfg_wr = 0, cfg_sel = 0;
  logic [7:0] cfg_wdata = 8'h00;
  logic ent_ready = 0;
  logic ent_valid, ent_set_i, ent_set_x, x_mask;
  logic [15:0] ent_vec;

  always #5 clk = ~clk;

  irq_arbiter #(.NPER(NPER)) u0 (
    .clk(clk), .rst_n(rst_n), .insn_bnd(insn_bnd), .irq_n(irq_n),
    .xirq_n(xirq_n), .tmr_req(tmr_req), .per_req(per_req),
    .swi_stb(swi_stb), .trap_stb(trap_stb), .cpu_i(cpu_i), .x_clr(x_clr),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ent_ready(ent_ready), .ent_valid(ent_valid), .ent_vec(ent_vec),
    .ent_set_i(ent_set_i), .ent_set_x(ent_set_x), .x_mask(x_mask)
  );

  int errors = 0, checks = 0, wd = 0;
  bit done = 0;
  string cur = "R1";

  // behavioural reference state
  bit m_pend, m_si, m_sx, m_x, m_edge, m_swi, m_trap, m_mode, m_en, m_prev;
  int m_id, m_promo;
  logic [15:0] m_vec;
  int ord[$];
  bit el[NSRC];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_si = 0; m_sx = 0; m_x = 1; m_edge = 0; m_swi = 0;
      m_trap = 0; m_mode = 0; m_en = 0; m_prev = 1; m_id = 0; m_promo = 0;
      m_vec = 16'h0000;
    end else begin
      int win;
      bit take;
      el[0] = m_trap;
      el[1] = m_swi;
      el[2] = !xirq_n && !m_x;
      el[3] = m_en && (m_mode ? m_edge : !irq_n) && !cpu_i;
      el[4] = tmr_req && !cpu_i;
      for (int k = 0; k < NPER; k++) el[5 + k] = per_req[k] && !cpu_i;
      ord = {};
      ord.push_back(0); ord.push_back(1); ord.push_back(2);
      ord.push_back(3 + m_promo);
      for (int m = 0; m < NMASK; m++) if (m != m_promo) ord.push_back(3 + m);
      win = -1;
      foreach (ord[i]) if (win < 0 && el[ord[i]]) win = ord[i];
      take = m_pend && ent_ready;
      // edge latch (uses pre-edge mode)
      if (m_mode && m_prev && !irq_n) m_edge = 1;
      else if (!m_mode || (take && m_id == 3)) m_edge = 0;
      if (swi_stb) m_swi = 1; else if (take && m_id == 1) m_swi = 0;
      if (trap_stb) m_trap = 1; else if (take && m_id == 0) m_trap = 0;
      if (take && m_id == 2) m_x = 1; else if (x_clr) m_x = 0;
      m_prev = irq_n;
      if (take) m_pend = 0;
      else if (!m_pend && insn_bnd && win >= 0) begin
        m_pend = 1; m_id = win; m_vec = 16'hFFF8 - 16'(2 * win);
        m_si = 1; m_sx = (win == 2);
      end
      if (cfg_wr && !cfg_sel) begin m_mode = cfg_wdata[0]; m_en = cfg_wdata[1]; end
      if (cfg_wr && cfg_sel && int'(cfg_wdata) < NMASK) m_promo = int'(cfg_wdata);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (ent_valid !== m_pend || ent_vec !== m_vec || ent_set_i !== m_si ||
          ent_set_x !== m_sx || x_mask !== m_x) begin
        errors++;
        $display("FAIL %s model: actual v=%0b vec=%h i=%0b x=%0b xm=%0b expected v=%0b vec=%h i=%0b x=%0b xm=%0b",
                 cur, ent_valid, ent_vec, ent_set_i, ent_set_x, x_mask,
                 m_pend, m_vec, m_si, m_sx, m_x);
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bnd();
    insn_bnd = 1; cyc(1); insn_bnd = 0;
  endtask
  task automatic acc();
    ent_ready = 1; cyc(1); ent_ready = 0;
  endtask
  task automatic wr(input logic s, input logic [7:0] d);
    cfg_wr = 1; cfg_sel = s; cfg_wdata = d; cyc(1); cfg_wr = 0;
  endtask
  task automatic dchk(input string r, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s directed: actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1 reset state
    dchk("R1", {ent_valid, ent_vec}, {1'b0, 16'h0000});
    dchk("R1", {16'h0, x_mask}, 17'h1);

    cur = "R2";
    bnd();
    dchk("R2", {16'h0, ent_valid}, 17'h0);
    tmr_req = 1; cyc(2);
    dchk("R2", {16'h0, ent_valid}, 17'h0);
    bnd();
    cur = "R4";
    dchk("R4", {ent_valid, ent_vec}, {1'b1, 16'hFFF0});
    cur = "R3";
    per_req[0] = 1; cyc(3);
    dchk("R3", {ent_valid, ent_vec}, {1'b1, 16'hFFF0});
    acc();
    dchk("R3", {16'h0, ent_valid}, 17'h0);
    tmr_req = 0; per_req = '0;

    cur = "R5";
    per_req = 8'b1010_0000; bnd();
    dchk("R5", {ent_valid, ent_vec}, {1'b1, 16'hFFE4});
    acc();
    per_req = 8'b0000_0100; tmr_req = 1; bnd();
    dchk("R5", {ent_valid, ent_vec}, {1'b1, 16'hFFF0});
    acc();
    per_req = '0; tmr_req = 0;

    cur = "R8";
    irq_n = 0; bnd();
    dchk("R8", {16'h0, ent_valid}, 17'h0);
    cur = "R6";
    wr(1'b0, 8'h02); bnd();
    dchk("R6", {ent_valid, ent_vec}, {1'b1, 16'hFFF2});
    acc(); bnd();
    dchk("R6", {ent_valid, ent_vec}, {1'b1, 16'hFFF2});
    acc(); irq_n = 1; bnd();
    dchk("R6", {16'h0, ent_valid}, 17'h0);

    cur = "R9";
    cpu_i = 1; irq_n = 0; tmr_req = 1; per_req = 8'hFF; bnd();
    dchk("R9", {16'h0, ent_valid}, 17'h0);
    irq_n = 1; tmr_req = 0; per_req = '0; cpu_i = 0;

    cur = "R7";
    wr(1'b0, 8'h03); cyc(1);
    irq_n = 0; cyc(1); irq_n = 1; cyc(2); bnd();
    dchk("R7", {ent_valid, ent_vec}, {1'b1, 16'hFFF2});
    acc(); bnd();
    dchk("R7", {16'h0, ent_valid}, 17'h0);
    irq_n = 0; cyc(1); irq_n = 1; cyc(1);
    wr(1'b0, 8'h02); bnd();
    dchk("R7", {16'h0, ent_valid}, 17'h0);

    cur = "R10";
    cpu_i = 1; xirq_n = 0; bnd();
    dchk("R10", {16'h0, ent_valid}, 17'h0);
    x_clr = 1; cyc(1); x_clr = 0;
    dchk("R10", {16'h0, x_mask}, 17'h0);
    bnd();
    dchk("R10", {ent_valid, ent_vec}, {1'b1, 16'hFFF4});
    cur = "R12";
    dchk("R12", {15'h0, ent_set_i, ent_set_x}, 17'h3);
    acc();
    dchk("R10", {16'h0, x_mask}, 17'h1);
    bnd();
    dchk("R10", {16'h0, ent_valid}, 17'h0);
    xirq_n = 1; x_clr = 1; cyc(1); x_clr = 0;

    cur = "R11";
    swi_stb = 1; cyc(1); swi_stb = 0; cyc(3);
    trap_stb = 1; cyc(1); trap_stb = 0; bnd();
    dchk("R11", {ent_valid, ent_vec}, {1'b1, 16'hFFF8});
    acc(); bnd();
    dchk("R11", {ent_valid, ent_vec}, {1'b1, 16'hFFF6});
    dchk("R12", {15'h0, ent_set_i, ent_set_x}, 17'h2);
    acc(); bnd();
    dchk("R11", {16'h0, ent_valid}, 17'h0);
    cpu_i = 0;

    cur = "R13";
    irq_n = 0; tmr_req = 1; wr(1'b1, 8'd1); bnd();
    dchk("R13", {ent_valid, ent_vec}, {1'b1, 16'hFFF0});
    acc(); wr(1'b1, 8'd200); bnd();
    dchk("R13", {ent_valid, ent_vec}, {1'b1, 16'hFFF0});
    acc(); wr(1'b1, 8'd0); bnd();
    dchk("R13", {ent_valid, ent_vec}, {1'b1, 16'hFFF2});
    acc(); per_req[3] = 1; wr(1'b1, 8'd5); bnd();
    dchk("R13", {ent_valid, ent_vec}, {1'b1, 16'hFFE8});
    acc();
    irq_n = 1; tmr_req = 0; per_req = '0;

    cur = "R5";
    for (int n = 0; n < 4000; n++) begin
      insn_bnd  = ($urandom_range(0, 2) == 0);
      irq_n     = ($urandom_range(0, 3) != 0);
      xirq_n    = ($urandom_range(0, 5) != 0);
      tmr_req   = ($urandom_range(0, 4) == 0);
      per_req   = NPER'($urandom) & NPER'($urandom) & NPER'($urandom);
      swi_stb   = ($urandom_range(0, 30) == 0);
      trap_stb  = ($urandom_range(0, 40) == 0);
      cpu_i     = ($urandom_range(0, 3) == 0);
      x_clr     = ($urandom_range(0, 20) == 0);
      ent_ready = ($urandom_range(0, 2) == 0);
      cfg_wr    = ($urandom_range(0, 25) == 0);
      cfg_sel   = 1'($urandom);
      cfg_wdata = cfg_sel ? 8'($urandom_range(0, 14)) : 8'($urandom_range(0, 3));
      cyc(1);
    end
    insn_bnd = 0; ent_ready = 0; cfg_wr = 0; swi_stb = 0; trap_stb = 0; x_clr = 0;
    cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule